// File: doc/BRIEF.md
# Burst Address Sequencer

This block sits in front of a synchronous cache SRAM array and turns one captured address into a four-beat burst. An access starts when the processor or the cache controller pulls its address-status strobe low. The full external address is then registered. The upper bits go straight to the array. The two low bits come from an internal beat counter, which moves forward only on cycles where the advance strobe is low. The processor strobe is honoured only while the first chip select is low. The controller strobe is never gated.

A static ordering pin chooses how the low bits are visited. In linear order they count up modulo four from the start value. In interleaved order they are the start value XOR a beat count that runs 0, 1, 2, 3. A registered valid-cycle output tells the array which cycles carry a real access: a start, or an accepted advance.

The controller has two states. `SEQ_IDLE` is entered at reset and means no burst has been captured yet. Its only transition is *start*, which goes to `SEQ_ACTIVE`. `SEQ_ACTIVE` has three transitions, all of which stay in `SEQ_ACTIVE`: *restart* (a new strobe reloads the address), *step* (advance moves the beat) and *hold* (nothing changes).

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `addr_o` is all zeros and `cyc_valid_o` is 0.
- R2: If `ads_proc_n`=0 and `cs1_n`=0 at a rising edge, then after that edge the upper bits of `addr_o` equal the upper bits of `addr_i`, the low two bits equal `addr_i[1:0]`, and `cyc_valid_o`=1.
- R3: If `ads_proc_n`=0 while `cs1_n`=1, and `ads_ctrl_n`=1 and `adv_n`=1, then `addr_o` is unchanged and `cyc_valid_o`=0 after the edge.
- R4: If `ads_ctrl_n`=0, the address is loaded as in R2 whatever the level of `cs1_n`. This includes the case where a processor strobe is blocked in the same cycle.
- R5: If both strobes are low in the same cycle, exactly one load of the present `addr_i` takes place and the beat restarts at the start value.
- R6: With `order_lin`=1, after k accepted advances the low two bits are (start + k) mod 4.
- R7: With `order_lin`=0, after k accepted advances the low two bits are start XOR (k mod 4).
- R8: In `SEQ_ACTIVE`, a cycle with `adv_n`=1 and no accepted strobe leaves `addr_o` unchanged and drives `cyc_valid_o`=0.
- R9: The fourth accepted advance after a start brings the low two bits back to the start value.
- R10: The upper bits of `addr_o` change only on an accepted strobe. Advances never change them.
- R11: In `SEQ_IDLE`, `adv_n`=0 alone has no effect: `addr_o` stays zero and `cyc_valid_o` stays 0.
- R12: An accepted strobe in the same cycle as `adv_n`=0 loads the address and restarts at beat 0. The advance is not applied.
- R13: `cyc_valid_o` is 1 in the cycle after an accepted strobe or an accepted advance, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address, captured on an accepted strobe |
| ads_proc_n | input | 1 | Processor address-status strobe, active low, gated by `cs1_n` |
| ads_ctrl_n | input | 1 | Controller address-status strobe, active low, never gated |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | First chip select, active low; when high it blocks `ads_proc_n` |
| order_lin | input | 1 | Static ordering select: 1 = linear, 0 = interleaved |
| addr_o | output | ADDR_W | Registered upper address with the sequenced low two bits |
| cyc_valid_o | output | 1 | High for one cycle after each start or accepted advance |

## Verification
The bench builds the block with `ADDR_W`=12 and `BEAT_W`=2. The narrow address lets random stimulus hit every start value in both orderings many times. Twelve bits still leave ten upper bits, enough to see whether the upper field leaked during a step. Keeping `BEAT_W` at two gives a full four-beat wrap within a few cycles. Random traffic therefore passes through wrap, restart in mid-burst and strobe collisions often.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } start_src_e;

endpackage

// File: rtl/bseq_start_arb.sv
module bseq_start_arb
    import bseq_pkg::*;
(
    input  logic ads_proc_n,
    input  logic ads_ctrl_n,
    input  logic cs1_n,
    output logic start_o
);

    start_src_e src;

    // Processor strobe wins a collision, but only while chip select allows it
    always_comb begin
        if (!ads_proc_n && !cs1_n) begin
            src = SRC_PROC;
        end else if (!ads_ctrl_n) begin
            src = SRC_CTRL;
        end else begin
            src = SRC_NONE;
        end
    end

    assign start_o = (src != SRC_NONE);

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] base_i,
    input  logic              step_i,
    input  logic              linear_i,
    output logic [BEAT_W-1:0] beat_o
);

    logic [BEAT_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] lin_w;
    logic [BEAT_W-1:0] ilv_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign lin_w = base_q + cnt_q;

    for (genvar g = 0; g < BEAT_W; g++) begin : g_ilv
        assign ilv_w[g] = base_q[g] ^ cnt_q[g];
    end

    assign beat_o = linear_i ? lin_w : ilv_w;

    // R2: a load presents the start value as the first beat
    p_load_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_o == $past(base_i)));

    // R6: in linear order each accepted step adds one modulo the burst length
    p_step_lin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && linear_i) |=>
            (!linear_i || beat_o == BEAT_W'($past(beat_o) + 1'b1)));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              cs1_n,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cyc_valid_o
);

    localparam int UP_W = ADDR_W - BEAT_W;

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic              start;
    logic              step;
    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] beat;
    logic              valid_q;

    bseq_start_arb u_arb (
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .cs1_n      (cs1_n),
        .start_o    (start)
    );

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (start),
        .base_i   (addr_i[BEAT_W-1:0]),
        .step_i   (step),
        .linear_i (order_lin),
        .beat_o   (beat)
    );

    // Next state and step decision
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start) state_d = SEQ_ACTIVE;
            end
            SEQ_ACTIVE: begin
                step = !adv_n && !start;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Upper address and valid-cycle registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            valid_q <= 1'b0;
        end else begin
            if (start) upper_q <= addr_i[ADDR_W-1:BEAT_W];
            valid_q <= start || step;
        end
    end

    // Outputs
    always_comb begin
        addr_o      = {upper_q, beat};
        cyc_valid_o = valid_q;
    end

    // R2: an accepted strobe captures the upper address and flags a valid cycle
    p_load_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_i[ADDR_W-1:BEAT_W])
                   && cyc_valid_o));

    // R3: a processor strobe blocked by chip select changes nothing
    p_cs_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n && cs1_n && ads_ctrl_n && adv_n) |=>
            ((($stable(addr_o)) || !$stable(order_lin)) && !cyc_valid_o));

    // R8: no strobe and no advance holds the address
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && ads_ctrl_n && (ads_proc_n || cs1_n)) |=>
            (($stable(addr_o) || !$stable(order_lin)) && !cyc_valid_o));

    // R10: upper bits move only on an accepted strobe
    p_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    // R11: advance before any burst has no effect
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && !start) |=> (addr_o == '0 && !cyc_valid_o));

    // R13: an accepted advance flags a valid cycle
    p_valid_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cyc_valid_o);

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

    localparam int AW = 12;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          ads_proc_n = 1'b1;
    logic          ads_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          cs1_n = 1'b1;
    logic          order_lin = 1'b1;
    logic [AW-1:0] addr_o;
    logic          cyc_valid_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench model state
    logic [AW-BW-1:0] m_up = '0;
    logic [BW-1:0]    m_base = '0;
    logic [BW-1:0]    m_cnt = '0;
    bit               m_act = 1'b0;
    bit               m_val = 1'b0;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
        .cs1_n(cs1_n), .order_lin(order_lin),
        .addr_o(addr_o), .cyc_valid_o(cyc_valid_o)
    );

    always #4 clk = ~clk;

    function automatic logic [BW-1:0] seq_bits(logic [BW-1:0] b, logic [BW-1:0] k, logic lin);
        return lin ? BW'(b + k) : (b ^ k);
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        return {m_up, seq_bits(m_base, m_cnt, order_lin)};
    endfunction

    task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, advance one rising edge, check at the next falling edge
    task automatic cyc(logic [AW-1:0] a, logic pn, logic cn, logic av, logic cs, string tag);
        bit proc_ok, st, stp;
        string t;
        addr_i = a; ads_proc_n = pn; ads_ctrl_n = cn; adv_n = av; cs1_n = cs;
        proc_ok = !pn && !cs;
        st  = proc_ok || !cn;
        stp = !st && m_act && !av;
        t = tag;
        if (t == "") begin
            if (st && !pn && !cn && !cs) t = "R5";
            else if (st && !av && m_act) t = "R12";
            else if (st && !cn) t = "R4";
            else if (st) t = "R2";
            else if (!m_act) t = "R11";
            else if (stp && m_cnt == 2'd3) t = "R9";
            else if (stp) t = order_lin ? "R6" : "R7";
            else if (!pn && cs) t = "R3";
            else t = "R8";
        end
        @(posedge clk);
        if (st) begin
            m_up = a[AW-1:BW]; m_base = a[BW-1:0]; m_cnt = '0; m_act = 1'b1; m_val = 1'b1;
        end else if (stp) begin
            m_cnt = m_cnt + 1'b1; m_val = 1'b1;
        end else begin
            m_val = 1'b0;
        end
        @(negedge clk);
        chk(t, addr_o, exp_addr());
        chk({t, "/R13 valid"}, AW'(cyc_valid_o), AW'(m_val));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [BW-1:0] s;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 in reset addr", addr_o, '0);
        chk("R1 in reset valid", AW'(cyc_valid_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset addr", addr_o, '0);
        chk("R1 after reset valid", AW'(cyc_valid_o), '0);

        // R11: advance and blocked strobe in idle
        cyc(12'h3F5, 1, 1, 0, 1, "R11 idle advance");
        cyc(12'h3F5, 0, 1, 0, 1, "R11 idle blocked proc");

        // R2 then linear beats R6, wrap R9, upper kept R10
        order_lin = 1'b1;
        cyc(12'hABD, 0, 1, 1, 0, "R2 proc load");
        cyc(12'h000, 1, 1, 0, 1, "R6 linear beat1");
        cyc(12'hFFF, 1, 1, 1, 1, "R8 hold");
        cyc(12'h555, 1, 1, 0, 1, "R6 linear beat2");
        cyc(12'h555, 1, 1, 0, 1, "R10 linear beat3 upper kept");
        cyc(12'h555, 1, 1, 0, 1, "R9 linear wrap");
        chk("R9 back to start", addr_o, 12'hABD);

        // R3 blocked processor strobe
        cyc(12'h123, 0, 1, 1, 1, "R3 proc blocked");
        chk("R3 address kept", addr_o, 12'hABD);

        // R4 controller strobe with chip select high, interleaved R7
        order_lin = 1'b0;
        cyc(12'h7C2, 1, 0, 1, 1, "R4 ctrl load cs high");
        cyc(12'h000, 1, 1, 0, 1, "R7 ilv beat1");
        chk("R7 2^1", addr_o, 12'h7C3);
        cyc(12'h000, 1, 1, 0, 1, "R7 ilv beat2");
        chk("R7 2^2", addr_o, 12'h7C0);
        cyc(12'h000, 1, 1, 0, 1, "R7 ilv beat3");
        chk("R7 2^3", addr_o, 12'h7C1);
        cyc(12'h000, 1, 1, 0, 1, "R9 ilv wrap");
        chk("R9 ilv back", addr_o, 12'h7C2);

        // R5 both strobes, R12 strobe with advance, R4 blocked proc plus ctrl
        cyc(12'h9A7, 0, 0, 1, 0, "R5 both strobes");
        cyc(12'h9A7, 1, 1, 0, 1, "R7 after collision");
        cyc(12'h461, 0, 1, 0, 0, "R12 start over advance");
        chk("R12 beat zero", addr_o, 12'h461);
        cyc(12'h2EE, 0, 0, 0, 1, "R4 ctrl with blocked proc");

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic pn, cn, av, cs;
            a  = AW'($urandom);
            s  = BW'($urandom);
            pn = ($urandom % 5) != 0;
            cn = ($urandom % 6) != 0;
            av = ($urandom % 3) == 0;
            cs = ($urandom % 3) == 0;
            if (($urandom % 40) == 0 && s[0]) order_lin = ~order_lin;
            cyc(a, pn, cn, av, cs, "");
        end

        // Reset again mid-burst
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid burst addr", addr_o, '0);
        chk("R1 reset mid burst valid", AW'(cyc_valid_o), '0);

        finish_run();
    end

endmodule